// File: doc/BRIEF.md
# Scan-Length Command Decoder for a Two-Pin Debug TAP

This block watches a target's debug test-access port from the inside. It follows the standard 16-state TAP controller using the TCK and TMS pins. While a harmless instruction is loaded, it measures the length of each data-register scan: the number of TCK edges spent in Shift-DR between a Capture-DR and the next Update-DR. The lengths are the payload. A scan of length zero (a capture followed by an update with no shift) is a value like any other.

A command is the list of lengths gathered since the TAP last entered Run-Test/Idle, and the next entry into that state closes it. The three-value command 0, 0, 1 locks the control level at 2. Once the level is locked, a two-value command is read as an opcode and a parameter. Opcode 2 writes the mode-select register and opcode 0 writes the state-control register. The state-control write can also turn on the four-wire mode enable.

The TCK and TMS pins are brought into the system clock domain through synchronisers, and the TAP state advances once per detected TCK rising edge. Write strobes are single system-clock pulses, and each strobe comes with its decoded fields.

Top module: `tapc_scan_decoder`

## Requirements
- R1: A scan value equals the number of TCK rising edges seen while the TAP is in Shift-DR, counted from entry to Capture-DR until entry to Update-DR. Shifting resumed through Exit2-DR adds to the same count.
- R2: A pass from Capture-DR to Update-DR through Exit1-DR, with or without Pause-DR and Exit2-DR, records 0. While unlocked, ctl_level equals the number of leading zero values in the open command (saturating at 7). It returns to 0 when Run-Test/Idle is entered without a lock.
- R3: A command closed with exactly the values 0, 0, 1 sets ctl_locked and makes ctl_level 2. Any other command, such as 0, 0, 2, does not lock.
- R4: While locked, a two-value command with first value 2 and second value p gives one stc2_wr pulse with stc2_cond = p[4], stc2_sel = p[3:2] and stc2_val = p[1:0].
- R5: While locked, a two-value command with first value 0 and second value p gives one stmc_wr pulse with stmc_sel = p[4:2], stmc_x = p[1] and stmc_y = p[0]. When stmc_sel is 0, four_wire_en becomes 1 if p[1:0] is 01 and 0 otherwise. Any other stmc_sel leaves four_wire_en unchanged.
- R6: No write strobe is produced while unlocked, or for a first value other than 0 or 2.
- R7: A value above 31 makes the command invalid. The command is discarded at Run-Test/Idle with no strobe and no lock. A value of exactly 31 is still valid.
- R8: Test-Logic-Reset clears ctl_level, ctl_locked and four_wire_en. Test-Logic-Reset is reached through five TCK edges with TMS high, or through rst_n.
- R9: Each write strobe is high for exactly one clk cycle per decoded command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, puts the TAP in Test-Logic-Reset |
| tck | input | 1 | Test clock pin, asynchronous to clk |
| tms | input | 1 | Test mode select pin, sampled on TCK rising edges |
| ctl_level | output | 3 | Current control level |
| ctl_locked | output | 1 | Control level locked at 2 |
| four_wire_en | output | 1 | Four-wire mode enable |
| stc2_wr | output | 1 | Mode-select write strobe |
| stc2_cond | output | 1 | Mode-select condition bit |
| stc2_sel | output | 2 | Mode-select selector field |
| stc2_val | output | 2 | Mode-select value field |
| stmc_wr | output | 1 | State-control write strobe |
| stmc_sel | output | 3 | State-control selector field |
| stmc_x | output | 1 | State-control x bit |
| stmc_y | output | 1 | State-control y bit |

## Verification
The hardest case to reach is a scan whose length is split by a pause: the TAP leaves Shift-DR, passes through Pause-DR and Exit2-DR, and returns to Shift-DR before updating. The count must not restart on the way back. The bench drives TMS edge by edge to walk this path inside a locked opcode and checks the fields of the resulting strobe. It also walks the zero-length scan through the pause states and drives scans of exactly 31 and 33 shifts, to cover both sides of the overflow boundary.

// File: rtl/tapc_pkg.sv
package tapc_pkg;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SHIFT_DR, TS_EXIT1_DR, TS_PAUSE_DR, TS_EXIT2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SHIFT_IR, TS_EXIT1_IR, TS_PAUSE_IR, TS_EXIT2_IR, TS_UPD_IR
  } tap_state_e;

  // Standard TAP controller transition on one TCK rising edge
  function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
    tap_state_e n;
    case (s)
      TS_RESET:    n = tms ? TS_RESET    : TS_IDLE;
      TS_IDLE:     n = tms ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_DR:   n = tms ? TS_SEL_IR   : TS_CAP_DR;
      TS_CAP_DR:   n = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_SHIFT_DR: n = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
      TS_EXIT1_DR: n = tms ? TS_UPD_DR   : TS_PAUSE_DR;
      TS_PAUSE_DR: n = tms ? TS_EXIT2_DR : TS_PAUSE_DR;
      TS_EXIT2_DR: n = tms ? TS_UPD_DR   : TS_SHIFT_DR;
      TS_UPD_DR:   n = tms ? TS_SEL_DR   : TS_IDLE;
      TS_SEL_IR:   n = tms ? TS_RESET    : TS_CAP_IR;
      TS_CAP_IR:   n = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_SHIFT_IR: n = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
      TS_EXIT1_IR: n = tms ? TS_UPD_IR   : TS_PAUSE_IR;
      TS_PAUSE_IR: n = tms ? TS_EXIT2_IR : TS_PAUSE_IR;
      TS_EXIT2_IR: n = tms ? TS_UPD_IR   : TS_SHIFT_IR;
      default:     n = tms ? TS_SEL_DR   : TS_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/tapc_sync.sv
module tapc_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int CHAIN_W = STAGES * WIDTH;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[CHAIN_W-WIDTH-1:0], d};
  end

  assign q = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/tapc_tap_fsm.sv
module tapc_tap_fsm
  import tapc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tck_rise,
  input  logic       tms,
  output tap_state_e state,
  output logic       shift_tick,
  output logic       cap_enter,
  output logic       upd_enter,
  output logic       idle_enter,
  output logic       in_reset
);
  tap_state_e nxt;

  always_comb nxt = tap_next(state, tms);

  assign shift_tick = tck_rise && (state == TS_SHIFT_DR);
  assign cap_enter  = tck_rise && (nxt == TS_CAP_DR);
  assign in_reset   = (state == TS_RESET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= TS_RESET;
      upd_enter  <= 1'b0;
      idle_enter <= 1'b0;
    end else begin
      upd_enter  <= tck_rise && (nxt == TS_UPD_DR);
      idle_enter <= tck_rise && (nxt == TS_IDLE) && (state != TS_IDLE);
      if (tck_rise) state <= nxt;
    end
  end
endmodule

// File: rtl/tapc_shift_count.sv
module tapc_shift_count #(
  parameter int CP_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_enter,
  input  logic            shift_tick,
  output logic [CP_W-1:0] value,
  output logic            over
);
  localparam int             CNT_W = CP_W + 1;
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(1) << CP_W;

  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c);
    return (c == LIMIT) ? c : c + CNT_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (cap_enter)  cnt <= '0;
    else if (shift_tick) cnt <= step(cnt);
  end

  assign value = cnt[CP_W-1:0];
  assign over  = cnt[CP_W];
endmodule

// File: rtl/tapc_cmd_decode.sv
module tapc_cmd_decode #(
  parameter int CP_W       = 5,
  parameter int LVL_W      = 3,
  parameter int LOCK_LEVEL = 2,
  parameter int OP_STC2    = 2,
  parameter int OP_STMC    = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tap_reset,
  input  logic             upd_enter,
  input  logic             idle_enter,
  input  logic [CP_W-1:0]  value,
  input  logic             over,
  output logic [LVL_W-1:0] ctl_level,
  output logic             ctl_locked,
  output logic             four_wire_en,
  output logic             stc2_wr,
  output logic             stc2_cond,
  output logic [1:0]       stc2_sel,
  output logic [1:0]       stc2_val,
  output logic             stmc_wr,
  output logic [2:0]       stmc_sel,
  output logic             stmc_x,
  output logic             stmc_y
);
  localparam int             NV_W    = 3;
  localparam logic [NV_W-1:0] NV_MAX  = NV_W'(4);
  localparam logic [LVL_W-1:0] LVL_MAX = '1;

  logic [2:0][CP_W-1:0] vals;
  logic [NV_W-1:0]      nvals;
  logic                 bad;
  logic                 zero_run;

  function automatic logic lock_match(input logic [NV_W-1:0] n, input logic [2:0][CP_W-1:0] v);
    return (n == NV_W'(3)) && (v[0] == '0) && (v[1] == '0) && (v[2] == CP_W'(1));
  endfunction

  function automatic logic [LVL_W-1:0] lvl_inc(input logic [LVL_W-1:0] l);
    return (l == LVL_MAX) ? l : l + LVL_W'(1);
  endfunction

  logic two_vals;
  assign two_vals = (nvals == NV_W'(2)) && !bad && ctl_locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vals <= '0; nvals <= '0; bad <= 1'b0; zero_run <= 1'b1;
      ctl_level <= '0; ctl_locked <= 1'b0; four_wire_en <= 1'b0;
      stc2_wr <= 1'b0; stc2_cond <= 1'b0; stc2_sel <= '0; stc2_val <= '0;
      stmc_wr <= 1'b0; stmc_sel <= '0; stmc_x <= 1'b0; stmc_y <= 1'b0;
    end else if (tap_reset) begin
      vals <= '0; nvals <= '0; bad <= 1'b0; zero_run <= 1'b1;
      ctl_level <= '0; ctl_locked <= 1'b0; four_wire_en <= 1'b0;
      stc2_wr <= 1'b0; stmc_wr <= 1'b0;
    end else begin
      stc2_wr <= 1'b0;
      stmc_wr <= 1'b0;
      if (upd_enter) begin
        if (nvals < NV_W'(3)) vals[nvals[1:0]] <= value;
        if (nvals != NV_MAX) nvals <= nvals + NV_W'(1);
        if (over) bad <= 1'b1;
        if (!ctl_locked) begin
          if (zero_run && !over && (value == '0)) ctl_level <= lvl_inc(ctl_level);
          else zero_run <= 1'b0;
        end
      end
      if (idle_enter) begin
        nvals    <= '0;
        bad      <= 1'b0;
        zero_run <= 1'b1;
        if (!bad && lock_match(nvals, vals)) begin
          ctl_locked <= 1'b1;
          ctl_level  <= LVL_W'(LOCK_LEVEL);
        end else if (!ctl_locked) begin
          ctl_level <= '0;
        end
        if (two_vals && (vals[0] == CP_W'(OP_STC2))) begin
          stc2_wr   <= 1'b1;
          stc2_cond <= vals[1][CP_W-1];
          stc2_sel  <= vals[1][CP_W-2 -: 2];
          stc2_val  <= vals[1][1:0];
        end
        if (two_vals && (vals[0] == CP_W'(OP_STMC))) begin
          stmc_wr  <= 1'b1;
          stmc_sel <= vals[1][CP_W-1 -: 3];
          stmc_x   <= vals[1][1];
          stmc_y   <= vals[1][0];
          if (vals[1][CP_W-1 -: 3] == 3'd0) four_wire_en <= (vals[1][1:0] == 2'b01);
        end
      end
    end
  end
endmodule

// File: rtl/tapc_scan_decoder.sv
module tapc_scan_decoder #(
  parameter int SYNC_STAGES = 2,
  parameter int CP_W        = 5,
  parameter int LVL_W       = 3,
  parameter int LOCK_LEVEL  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tck,
  input  logic             tms,
  output logic [LVL_W-1:0] ctl_level,
  output logic             ctl_locked,
  output logic             four_wire_en,
  output logic             stc2_wr,
  output logic             stc2_cond,
  output logic [1:0]       stc2_sel,
  output logic [1:0]       stc2_val,
  output logic             stmc_wr,
  output logic [2:0]       stmc_sel,
  output logic             stmc_x,
  output logic             stmc_y
);
  import tapc_pkg::*;

  logic [1:0]      pins_s;
  logic            tck_s, tms_s, tck_d, tck_rise;
  tap_state_e      tap_state;
  logic            shift_tick, cap_enter, upd_enter, idle_enter, tap_reset;
  logic [CP_W-1:0] scan_value;
  logic            scan_over;

  tapc_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) sync_i (
    .clk(clk), .rst_n(rst_n), .d({tck, tms}), .q(pins_s)
  );
  assign tck_s = pins_s[1];
  assign tms_s = pins_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tck_d <= 1'b0;
    else        tck_d <= tck_s;
  end
  assign tck_rise = tck_s && !tck_d;

  tapc_tap_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .tck_rise(tck_rise), .tms(tms_s),
    .state(tap_state), .shift_tick(shift_tick), .cap_enter(cap_enter),
    .upd_enter(upd_enter), .idle_enter(idle_enter), .in_reset(tap_reset)
  );

  tapc_shift_count #(.CP_W(CP_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .cap_enter(cap_enter), .shift_tick(shift_tick),
    .value(scan_value), .over(scan_over)
  );

  tapc_cmd_decode #(.CP_W(CP_W), .LVL_W(LVL_W), .LOCK_LEVEL(LOCK_LEVEL)) dec_i (
    .clk(clk), .rst_n(rst_n), .tap_reset(tap_reset),
    .upd_enter(upd_enter), .idle_enter(idle_enter),
    .value(scan_value), .over(scan_over),
    .ctl_level(ctl_level), .ctl_locked(ctl_locked), .four_wire_en(four_wire_en),
    .stc2_wr(stc2_wr), .stc2_cond(stc2_cond), .stc2_sel(stc2_sel), .stc2_val(stc2_val),
    .stmc_wr(stmc_wr), .stmc_sel(stmc_sel), .stmc_x(stmc_x), .stmc_y(stmc_y)
  );
endmodule

// File: rtl/tapc_scan_decoder_chk.sv
module tapc_scan_decoder_chk #(
  parameter int LVL_W      = 3,
  parameter int LOCK_LEVEL = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tap_reset,
  input logic             idle_enter,
  input logic [LVL_W-1:0] ctl_level,
  input logic             ctl_locked,
  input logic             four_wire_en,
  input logic             stc2_wr,
  input logic             stmc_wr
);
  // R9
  stc2_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) stc2_wr |=> !stc2_wr);
  // R9
  stmc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) stmc_wr |=> !stmc_wr);
  // R6
  stc2_locked_chk: assert property (@(posedge clk) disable iff (!rst_n) stc2_wr |-> ctl_locked);
  // R6
  stmc_locked_chk: assert property (@(posedge clk) disable iff (!rst_n) stmc_wr |-> ctl_locked);
  // R3
  lock_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_locked) |-> (ctl_level == LVL_W'(LOCK_LEVEL)));
  // R5
  four_wire_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(four_wire_en) |-> stmc_wr);
  // R8
  tap_reset_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tap_reset |=> (!ctl_locked && (ctl_level == '0) && !four_wire_en));
  // R2
  level_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_enter && !ctl_locked) |=> (ctl_locked || (ctl_level == '0)));
endmodule

bind tapc_scan_decoder tapc_scan_decoder_chk #(.LVL_W(LVL_W), .LOCK_LEVEL(LOCK_LEVEL)) chk_i (
  .clk(clk), .rst_n(rst_n), .tap_reset(tap_reset), .idle_enter(idle_enter),
  .ctl_level(ctl_level), .ctl_locked(ctl_locked), .four_wire_en(four_wire_en),
  .stc2_wr(stc2_wr), .stmc_wr(stmc_wr)
);

// File: tb/tapc_scan_decoder_tb_top.sv
`timescale 1ns/1ps
module tapc_scan_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tck = 1'b0;
  logic tms = 1'b1;
  logic [2:0] ctl_level;
  logic ctl_locked, four_wire_en;
  logic stc2_wr, stc2_cond, stmc_wr, stmc_x, stmc_y;
  logic [1:0] stc2_sel, stc2_val;
  logic [2:0] stmc_sel;

  int checks = 0;
  int errors = 0;
  int stc2_hi = 0, stmc_hi = 0;
  logic [4:0] stc2_got = '0;
  logic [4:0] stmc_got = '0;
  bit done = 0;

  always #2 clk = ~clk;

  tapc_scan_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .tck(tck), .tms(tms),
    .ctl_level(ctl_level), .ctl_locked(ctl_locked), .four_wire_en(four_wire_en),
    .stc2_wr(stc2_wr), .stc2_cond(stc2_cond), .stc2_sel(stc2_sel), .stc2_val(stc2_val),
    .stmc_wr(stmc_wr), .stmc_sel(stmc_sel), .stmc_x(stmc_x), .stmc_y(stmc_y)
  );

  // Strobe monitor: counts every clk cycle a strobe is high, latches fields
  always @(negedge clk) begin
    if (stc2_wr) begin stc2_hi++; stc2_got = {stc2_cond, stc2_sel, stc2_val}; end
    if (stmc_wr) begin stmc_hi++; stmc_got = {stmc_sel, stmc_x, stmc_y}; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tck_cycle(input logic t);
    @(negedge clk); tms = t; tck = 1'b0;
    repeat (4) @(negedge clk);
    tck = 1'b1;
    repeat (4) @(negedge clk);
    tck = 1'b0;
  endtask

  // From Run-Test/Idle or Update-DR, perform one DR scan of n shift edges
  task automatic scan(input int n);
    tck_cycle(1); tck_cycle(0);
    if (n == 0) begin
      tck_cycle(1); tck_cycle(1);
    end else begin
      tck_cycle(0);
      for (int i = 0; i < n - 1; i++) tck_cycle(0);
      tck_cycle(1); tck_cycle(1);
    end
  endtask

  task automatic scan_zero_paused();
    tck_cycle(1); tck_cycle(0); tck_cycle(1);
    tck_cycle(0); tck_cycle(0); tck_cycle(1); tck_cycle(1);
  endtask

  // a shift edges, pause, resume, b more shift edges
  task automatic scan_split(input int a, input int b);
    tck_cycle(1); tck_cycle(0); tck_cycle(0);
    for (int i = 0; i < a - 1; i++) tck_cycle(0);
    tck_cycle(1); tck_cycle(0); tck_cycle(1); tck_cycle(0);
    for (int i = 0; i < b - 1; i++) tck_cycle(0);
    tck_cycle(1); tck_cycle(1);
  endtask

  task automatic end_cmd();
    tck_cycle(0); tck_cycle(0); tck_cycle(0);
  endtask

  task automatic tap_reset_to_idle();
    for (int i = 0; i < 5; i++) tck_cycle(1);
    tck_cycle(0);
  endtask

  task automatic cmd2(input int a, input int b);
    scan(a); scan(b); end_cmd();
  endtask

  task automatic t_reset();
    check(ctl_level == 0, "R8 level after reset", ctl_level, 0);
    check(ctl_locked == 0, "R8 lock after reset", ctl_locked, 0);
    check(four_wire_en == 0, "R8 four_wire after reset", four_wire_en, 0);
  endtask

  task automatic t_unlocked();
    int s0 = stc2_hi;
    cmd2(2, 9);
    check(stc2_hi == s0, "R6 no strobe while unlocked", stc2_hi - s0, 0);
  endtask

  task automatic t_level();
    scan(0);
    repeat (8) @(negedge clk);
    check(ctl_level == 1, "R2 level after one zero scan", ctl_level, 1);
    scan_zero_paused();
    repeat (8) @(negedge clk);
    check(ctl_level == 2, "R2 level after paused zero scan", ctl_level, 2);
    check(ctl_locked == 0, "R2 not locked mid-command", ctl_locked, 0);
    scan(2); end_cmd();
    check(ctl_locked == 0, "R3 0,0,2 does not lock", ctl_locked, 0);
    check(ctl_level == 0, "R2 level back to 0", ctl_level, 0);
  endtask

  task automatic t_lock();
    scan(0); scan(0); scan(1); end_cmd();
    check(ctl_locked == 1, "R3 lock set", ctl_locked, 1);
    check(ctl_level == 2, "R3 level 2", ctl_level, 2);
  endtask

  task automatic t_stc2();
    int s0 = stc2_hi;
    cmd2(2, 9);
    check(stc2_hi == s0 + 1, "R4 R9 one stc2 pulse", stc2_hi - s0, 1);
    check(stc2_got == 5'b01001, "R4 stc2 fields", stc2_got, 5'b01001);
    s0 = stc2_hi;
    scan_split(1, 1); scan(22); end_cmd();
    check(stc2_hi == s0 + 1, "R1 split scan gives opcode 2", stc2_hi - s0, 1);
    check(stc2_got == 5'b10110, "R1 R4 fields after split scan", stc2_got, 5'b10110);
  endtask

  task automatic t_stmc();
    int s0 = stmc_hi;
    cmd2(0, 1);
    check(stmc_hi == s0 + 1, "R5 R9 one stmc pulse", stmc_hi - s0, 1);
    check(stmc_got == 5'b00001, "R5 stmc fields", stmc_got, 1);
    check(four_wire_en == 1, "R5 four_wire set", four_wire_en, 1);
    cmd2(0, 3);
    check(four_wire_en == 0, "R5 four_wire cleared by xy=11", four_wire_en, 0);
    cmd2(0, 1);
    s0 = stmc_hi;
    cmd2(0, 5);
    check(stmc_hi == s0 + 1 && stmc_got == 5'b00101, "R5 sel 1 strobe", stmc_got, 5);
    check(four_wire_en == 1, "R5 sel 1 leaves four_wire", four_wire_en, 1);
  endtask

  task automatic t_invalid();
    int s0 = stc2_hi;
    int m0 = stmc_hi;
    cmd2(2, 40);
    check(stc2_hi == s0, "R7 count 40 discarded", stc2_hi - s0, 0);
    cmd2(0, 33);
    check(stmc_hi == m0, "R7 count 33 discarded", stmc_hi - m0, 0);
    check(four_wire_en == 1, "R7 four_wire untouched", four_wire_en, 1);
    cmd2(5, 9);
    check(stc2_hi == s0 && stmc_hi == m0, "R6 unknown opcode ignored",
          stc2_hi + stmc_hi - s0 - m0, 0);
    cmd2(2, 31);
    check(stc2_hi == s0 + 1 && stc2_got == 5'b11111, "R7 count 31 accepted", stc2_got, 31);
  endtask

  task automatic t_tap_reset();
    int s0;
    for (int i = 0; i < 5; i++) tck_cycle(1);
    repeat (4) @(negedge clk);
    check(ctl_locked == 0, "R8 lock cleared by TAP reset", ctl_locked, 0);
    check(ctl_level == 0, "R8 level cleared", ctl_level, 0);
    check(four_wire_en == 0, "R8 four_wire cleared", four_wire_en, 0);
    tck_cycle(0);
    s0 = stc2_hi;
    cmd2(2, 9);
    check(stc2_hi == s0, "R8 R6 needs relock after reset", stc2_hi - s0, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    tap_reset_to_idle();
    t_unlocked();
    t_level();
    t_lock();
    t_stc2();
    t_stmc();
    t_invalid();
    t_tap_reset();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule